// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the parallel response of a circuit under test into one K-bit signature. It does not give every output its own compactor. On every accepted word, all K response bits are folded into a single shared shift register with modular polynomial feedback. The register is linear. So the final signature equals the XOR of the remainders that each output bit's stream alone would leave after serial division by the characteristic polynomial. For independent random errors, the chance that a faulty response gives the good signature is about 1/2^K, whatever the starting state.

A session begins with a clear that loads the seed and arms the block. Response words then arrive on a valid/ready stream. The input is refused (ready low) until the register has been seeded, because compacting unknown state would give a signature that is neither unique nor repeatable. A done strobe ends the session. It compares the signature with the good-machine value on the golden input and latches a pass/fail result with a valid flag. After done, the block refuses data until the next clear.

Stream rules: a word transfers only in a cycle where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high for any time. `in_ready` does not depend on `in_valid`. `in_ready` is low before the first clear, in any cycle in which `seed_clr` or `done` is high, and after done until the next clear.

Top module: `sigc_misr`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), and in the cycle after it, `sig` is 0, `in_ready` is 0, `cmp_valid` is 0 and `cmp_pass` is 0.
- R2: A cycle with `seed_clr` high makes `sig` equal SEED on the next cycle, arms the block and clears `cmp_valid` and `cmp_pass`. It takes priority over an offered word and over `done`.
- R3: An accepted word d moves `sig` from q to n, where fb = q[K-1], n[0] = d[0]^fb, and n[i] = q[i-1]^d[i]^(POLY[i]&fb) for i from 1 to K-1. Bit 0 of POLY is ignored; the x^K and x^0 terms are implied.
- R4: `in_ready` is high only while the block is armed and neither `seed_clr` nor `done` is high. In a cycle with no transfer and no clear, `sig` keeps its value.
- R5: With SEED zero, the signature after a session equals the XOR over j of the signature that bit j's stream alone (all other bits zero) would produce.
- R6: `done` while armed sets `cmp_valid` on the next cycle. It also sets `cmp_pass` to 1 exactly when `sig` in the done cycle equals `golden`, and disarms the block. Both flags then hold until the next clear.
- R7: `done` while not armed has no effect: `cmp_valid`, `cmp_pass` and `sig` are unchanged.
- R8: `cmp_pass` is never high while `cmp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_clr | input | 1 | Load seed and arm a new session |
| in_valid | input | 1 | Response word offered |
| in_data | input | K | Parallel response bits |
| in_ready | output | 1 | Block accepts a word this cycle |
| done | input | 1 | End session and compare |
| golden | input | K | Good-machine signature |
| sig | output | K | Current signature |
| cmp_valid | output | 1 | Comparison result is present |
| cmp_pass | output | 1 | Signature matched golden |

## Verification
The assertions assume that `rst_n` is held low for at least one clock before use and that `seed_clr`, `done` and `in_valid` change only between clock edges. The bench drives every input on the falling edge, releases reset only after several cycles, and holds `golden` steady around each done strobe. A behavioural model performs the polynomial reduction as shift-then-subtract. A set of per-bit serial remainders is compared with the signature when each session ends.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
  // Feedback mask with the constant term forced on
  function automatic logic [63:0] taps_with_unit(input logic [63:0] poly);
    return poly | 64'd1;
  endfunction
endpackage

// File: rtl/sigc_shift_core.sv
module sigc_shift_core #(
  parameter int K = 8,
  parameter logic [K-1:0] POLY = 8'h1D,
  parameter logic [K-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [K-1:0] d,
  output logic [K-1:0] q
);
  import sigc_pkg::*;
  localparam logic [63:0] TAPS = taps_with_unit(64'(POLY));

  logic         fb;
  logic [K-1:0] nxt;

  assign fb = q[K-1];

  // one XOR column per stage
  for (genvar i = 0; i < K; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = d[i] ^ fb;
    end else begin : g_body
      assign nxt[i] = q[i-1] ^ d[i] ^ (TAPS[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= SEED;
    else if (adv)   q <= nxt;
  end

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == SEED));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(q));
endmodule

// File: rtl/sigc_ctrl.sv
module sigc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_clr,
  input  logic done,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic close
);
  logic armed;

  assign in_ready = armed & ~done & ~seed_clr;
  assign accept   = in_valid & in_ready;
  assign close    = armed & done & ~seed_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (seed_clr) armed <= 1'b1;
    else if (close)    armed <= 1'b0;
  end

  p_close_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !in_ready);
  p_clear_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_clr |=> armed);
endmodule

// File: rtl/sigc_judge.sv
module sigc_judge #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         fire,
  input  logic [K-1:0] sig,
  input  logic [K-1:0] golden,
  output logic         cmp_valid,
  output logic         cmp_pass
);
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      cmp_valid <= 1'b0;
      cmp_pass  <= 1'b0;
    end else if (fire) begin
      cmp_valid <= 1'b1;
      cmp_pass  <= (sig == golden);
    end
  end

  p_pass_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pass |-> cmp_valid);
  p_valid_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_valid) |-> $past(fire));
  p_result_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !load) |=> (cmp_valid && $stable(cmp_pass)));
endmodule

// File: rtl/sigc_misr.sv
module sigc_misr #(
  parameter int K = 8,
  parameter logic [K-1:0] POLY = 8'h1D,
  parameter logic [K-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_clr,
  input  logic         in_valid,
  input  logic [K-1:0] in_data,
  output logic         in_ready,
  input  logic         done,
  input  logic [K-1:0] golden,
  output logic [K-1:0] sig,
  output logic         cmp_valid,
  output logic         cmp_pass
);
  logic accept, close;

  sigc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .seed_clr(seed_clr), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .accept(accept), .close(close)
  );

  sigc_shift_core #(.K(K), .POLY(POLY), .SEED(SEED)) u_core (
    .clk(clk), .rst_n(rst_n), .load(seed_clr), .adv(accept),
    .d(in_data), .q(sig)
  );

  sigc_judge #(.K(K)) u_judge (
    .clk(clk), .rst_n(rst_n), .load(seed_clr), .fire(close),
    .sig(sig), .golden(golden), .cmp_valid(cmp_valid), .cmp_pass(cmp_pass)
  );

  p_unarmed_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !seed_clr) |=> $stable(sig));
endmodule

// File: tb/sigc_misr_bench.sv
module sigc_misr_bench;
  localparam int K = 8;
  localparam logic [K-1:0] POLY = 8'h1D;
  localparam logic [K-1:0] SEED = 8'h00;

  logic clk = 0, rst_n = 0, seed_clr = 0, in_valid = 0, done = 0;
  logic [K-1:0] in_data = '0, golden = '0;
  logic in_ready, cmp_valid, cmp_pass;
  logic [K-1:0] sig;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // reference state
  logic [K-1:0] m_sig;
  logic [K-1:0] m_bit [K];
  bit m_armed, m_cv, m_cp;

  always #10 clk = ~clk;

  sigc_misr #(.K(K), .POLY(POLY), .SEED(SEED)) u_sigc_misr (
    .clk(clk), .rst_n(rst_n), .seed_clr(seed_clr), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .done(done), .golden(golden),
    .sig(sig), .cmp_valid(cmp_valid), .cmp_pass(cmp_pass)
  );

  // shift-then-reduce division step, then add the new word
  function automatic logic [K-1:0] divide_step(logic [K-1:0] r, logic [K-1:0] w);
    logic [K:0] t;
    t = {r, 1'b0};
    if (t[K]) t = t ^ {1'b1, POLY[K-1:1], 1'b1};
    return t[K-1:0] ^ w;
  endfunction

  task automatic chk(string tag, logic [K-1:0] act, logic [K-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive on falling edge, predict, compare after rising edge
  task automatic step(string tag, bit clr, bit v, logic [K-1:0] d, bit dn);
    bit exp_rdy;
    @(negedge clk);
    seed_clr = clr; in_valid = v; in_data = d; done = dn;
    #1;
    exp_rdy = m_armed && !dn && !clr;
    chk({tag, " R4 in_ready"}, K'(in_ready), K'(exp_rdy));
    if (clr) begin
      m_sig = SEED; m_armed = 1; m_cv = 0; m_cp = 0;
      for (int j = 0; j < K; j++) m_bit[j] = '0;
    end else if (dn && m_armed) begin
      m_cv = 1; m_cp = (m_sig == golden); m_armed = 0;
    end else if (v && exp_rdy) begin
      m_sig = divide_step(m_sig, d);
      for (int j = 0; j < K; j++) m_bit[j] = divide_step(m_bit[j], d & (K'(1) << j));
    end
    @(posedge clk); #1;
    chk({tag, " R3 sig"}, sig, m_sig);
    chk({tag, " R6 cmp_valid"}, K'(cmp_valid), K'(m_cv));
    chk({tag, " R8 cmp_pass"}, K'(cmp_pass), K'(m_cp));
  endtask

  task automatic check_linear(string tag);
    logic [K-1:0] acc = '0;
    for (int j = 0; j < K; j++) acc ^= m_bit[j];
    chk({tag, " R5 model xor of remainders"}, acc, m_sig);
    chk({tag, " R5 sig vs xor of remainders"}, sig, acc);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_sig = '0; m_armed = 0; m_cv = 0; m_cp = 0;
    for (int j = 0; j < K; j++) m_bit[j] = '0;
    // R1: reset state
    seed_clr = 1; in_valid = 1; in_data = 8'hFF; done = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sig in reset", sig, '0);
    chk("R1 in_ready in reset", K'(in_ready), '0);
    chk("R1 cmp_valid in reset", K'(cmp_valid), '0);
    @(negedge clk);
    rst_n = 1; seed_clr = 0; in_valid = 0; done = 0;
    @(posedge clk); #1;
    chk("R1 sig after reset", sig, '0);
    chk("R1 cmp_pass after reset", K'(cmp_pass), '0);

    // R7: done before arming is ignored; R4: data refused
    step("R7 unarmed done", 0, 0, '0, 1);
    step("R4 unarmed data", 0, 1, 8'hA5, 0);

    // R2: clear with an offered word
    step("R2 seed", 1, 1, 8'h3C, 0);
    chk("R2 sig equals seed", sig, SEED);

    // session A: random words with gaps
    for (int n = 0; n < 60; n++) begin
      logic [K-1:0] w;
      w = K'($urandom);
      step("R3 random", 0, ($urandom % 4) != 0, w, 0);
    end
    check_linear("session A");
    golden = m_sig;
    step("R6 done pass", 0, 1, 8'h11, 1);
    chk("R6 pass flag", K'(cmp_pass), 1);
    step("R4 after done", 0, 1, 8'h77, 0);
    step("R7 second done", 0, 0, '0, 1);
    chk("R7 flags held", K'(cmp_pass), 1);

    // session B: structured patterns, then a wrong golden
    step("R2 reseed", 1, 0, '0, 0);
    chk("R2 cmp_valid cleared", K'(cmp_valid), '0);
    for (int b = 0; b < K; b++) step("R3 walking one", 0, 1, K'(1) << b, 0);
    for (int n = 0; n < 5; n++) step("R3 all ones", 0, 1, '1, 0);
    step("R3 zero word", 0, 1, '0, 0);
    check_linear("session B");
    golden = m_sig ^ 8'h01;
    step("R6 done fail", 0, 0, '0, 1);
    chk("R6 fail flag", K'(cmp_pass), 0);

    // R2 priority over done, then a short session ending on a match
    step("R2 clear beats done", 1, 1, 8'hF0, 1);
    for (int n = 0; n < 12; n++) step("R3 burst", 0, 1, K'(n * 37 + 5), 0);
    check_linear("session C");
    golden = m_sig;
    step("R6 done pass C", 0, 0, '0, 1);
    repeat (2) step("R4 idle", 0, 0, '0, 0);
    finish_run();
  end
endmodule